// File: doc/BRIEF.md
# Page Write Buffer and Status Control

This block sits behind the serial command decoder of a byte-addressed nonvolatile memory. It gathers the data bytes of a page write into a page latch and records which bytes arrived. When chip select rises at a byte boundary, it commits those bytes to a small internal array in one timed internal write cycle. It also owns the status register, which holds the write-enable latch, the write-in-progress flag, two block-protect bits and a protect-enable bit. The protect-enable bit together with the active-low write-protect pin decides whether a status write is accepted.

The command decoder drives the block with single-cycle strobes on the system clock. Separate strobes set and clear the write-enable latch, open an array write with its start address, open a status write, deliver each received data byte, and mark the chip-select rising edge together with a flag that says whether the edge fell on a byte boundary. The array and the status register can be read at any time through a combinational read port and the status output.

Top module: `page_wr_ctrl`

## Requirements
- R1: After reset the status output is 0x00. Its layout is bit 7 protect-enable, bit 3 BP1, bit 2 BP0, bit 1 write-enable latch (WEL) and bit 0 write-in-progress (WIP). The other bits read 0.
- R2: A set strobe sets WEL and a clear strobe clears it when no cycle is running. A write-open or status-open strobe is ignored while WEL is 0, so the bytes and chip-select edge that follow leave the array and the status unchanged.
- R3: An array write places its bytes at consecutive offsets from the start address within one page. PAGE_BYTES is a power of two and pages start at multiples of it. The offset wraps from the last byte of the page to its first byte, and a later byte overwrites an earlier one at the same offset.
- R4: A commit updates only the array bytes that were received. Every other byte of the page keeps its old value.
- R5: A cycle starts only on a chip-select rising edge that is flagged byte-aligned, after at least one data byte. Any other edge discards the write, starts no cycle and leaves WEL unchanged.
- R6: WIP is 1 for exactly WR_CYCLES clocks, starting in the cycle after the accepted edge. WEL and WIP fall together when the cycle ends, and the written values are visible from that cycle.
- R7: While a cycle runs, the WEL strobes, the open strobes, the data bytes, chip-select edges and the write-protect pin have no effect on the cycle or on anything that follows it.
- R8: A status write takes its first data byte. Bit 7 of that byte goes to protect-enable and bits 3:2 go to BP1:BP0; its other bits are ignored. It follows the same WEL and commit rules as an array write and runs a full timed cycle.
- R9: When protect-enable is 1 and the write-protect pin is low at the commit edge, a status write is discarded with no cycle, and WEL stays set. When protect-enable is 0, the pin has no effect.
- R10: The array contents do not change while WIP is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Write-protect pin, active low |
| wel_set | input | 1 | Set write-enable latch strobe |
| wel_clr | input | 1 | Clear write-enable latch strobe |
| wr_start | input | 1 | Open an array write at start_addr |
| sr_start | input | 1 | Open a status register write |
| start_addr | input | AW | Array start address |
| byte_stb | input | 1 | Data byte received strobe |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | Chip-select rising edge strobe |
| cs_aligned | input | 1 | Edge fell on a byte boundary |
| rd_addr | input | AW | Array read address |
| rd_data | output | 8 | Array read data |
| status | output | 8 | Status register |

## Verification
The assertions assume that every strobe lasts one clock, that cs_aligned is meaningful only while cs_rise is high, and that rd_addr is held steady across any cycle whose data stability is being judged. The bench drives each strobe for exactly one clock and raises cs_aligned only alongside cs_rise. During an internal cycle it holds the read address fixed while it pushes commands and toggles the write-protect pin.

// File: rtl/page_wr_ctrl.sv
module page_wr_ctrl #(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wp_n,
  input  logic                         wel_set,
  input  logic                         wel_clr,
  input  logic                         wr_start,
  input  logic                         sr_start,
  input  logic [$clog2(MEM_BYTES)-1:0] start_addr,
  input  logic                         byte_stb,
  input  logic [7:0]                   byte_data,
  input  logic                         cs_rise,
  input  logic                         cs_aligned,
  input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
  output logic [7:0]                   rd_data,
  output logic [7:0]                   status
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int OW = $clog2(PAGE_BYTES);
  localparam int PW = AW - OW;
  localparam int CW = $clog2(WR_CYCLES + 1);

  typedef enum logic [1:0] {M_IDLE, M_ARRAY, M_STAT} mode_t;

  mode_t           mode;
  logic [PW-1:0]   page_q;
  logic [OW-1:0]   off_q;
  logic [7:0]      latch [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic [7:0]      sr_byte;
  logic            sr_got;
  logic            wpen, wel, busy, is_arr;
  logic [1:0]      bp;
  logic [CW-1:0]   cnt;
  logic [7:0]      mem [MEM_BYTES];

  wire blocked = wpen & ~wp_n;
  wire have    = (mode == M_ARRAY) ? |mask : ((mode == M_STAT) & sr_got);
  wire go      = cs_rise & cs_aligned & have & ~((mode == M_STAT) & blocked);

  assign rd_data = mem[rd_addr];
  assign status  = {wpen, 3'b000, bp, wel, busy};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= M_IDLE;
      page_q  <= '0;
      off_q   <= '0;
      mask    <= '0;
      sr_byte <= '0;
      sr_got  <= 1'b0;
      wpen    <= 1'b0;
      bp      <= '0;
      wel     <= 1'b0;
      busy    <= 1'b0;
      is_arr  <= 1'b0;
      cnt     <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) latch[i] <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
        wel  <= 1'b0;
        if (is_arr) begin
          for (int i = 0; i < PAGE_BYTES; i++)
            if (mask[i]) mem[{page_q, OW'(i)}] <= latch[i];
        end else begin
          wpen <= sr_byte[7];
          bp   <= sr_byte[3:2];
        end
      end
    end else if (cs_rise) begin
      mode <= M_IDLE;
      if (go) begin
        busy   <= 1'b1;
        cnt    <= CW'(WR_CYCLES);
        is_arr <= (mode == M_ARRAY);
      end
    end else begin
      if (wel_clr)      wel <= 1'b0;
      else if (wel_set) wel <= 1'b1;
      if (wr_start && wel) begin
        mode   <= M_ARRAY;
        page_q <= start_addr[AW-1:OW];
        off_q  <= start_addr[OW-1:0];
        mask   <= '0;
      end else if (sr_start && wel) begin
        mode   <= M_STAT;
        sr_got <= 1'b0;
      end else if (byte_stb) begin
        if (mode == M_ARRAY) begin
          latch[off_q] <= byte_data;
          mask[off_q]  <= 1'b1;
          off_q        <= off_q + OW'(1);
        end else if (mode == M_STAT && !sr_got) begin
          sr_byte <= byte_data;
          sr_got  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/page_wr_ctrl_chk.sv
module page_wr_ctrl_chk #(
  parameter int WR_CYCLES = 20,
  parameter int AW        = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_rise,
  input logic          cs_aligned,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data,
  input logic [7:0]    status
);
  int run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= 0;
    else        run <= status[0] ? run + 1 : 0;
  end

  AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n) $rose(status[0]) |-> $past(cs_rise && cs_aligned)); // R5
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) $rose(status[0]) |-> $past(status[1])); // R2
  AST_WEL_HELD: assert property (@(posedge clk) disable iff (!rst_n) status[0] |-> status[1]); // R7
  AST_WEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) $fell(status[0]) |-> !status[1]); // R6
  AST_WIP_BOUND: assert property (@(posedge clk) disable iff (!rst_n) status[0] |-> run < WR_CYCLES); // R6
  AST_WIP_FULL: assert property (@(posedge clk) disable iff (!rst_n) $fell(status[0]) |-> run == WR_CYCLES); // R6
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n) status[0] && $past(status[0]) |-> $stable(status[7:2])); // R8
  AST_ARRAY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) status[0] && $past(status[0]) && rd_addr == $past(rd_addr) |-> $stable(rd_data)); // R10
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) status[6:4] == 3'b000); // R1
endmodule

bind page_wr_ctrl page_wr_ctrl_chk #(.WR_CYCLES(WR_CYCLES), .AW($clog2(MEM_BYTES))) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_aligned(cs_aligned),
  .rd_addr(rd_addr), .rd_data(rd_data), .status(status));

// File: tb/tb_page_wr_ctrl.sv
`timescale 1ns/1ps
module tb_page_wr_ctrl;
  localparam int MB = 256, PB = 16, WC = 20;

  logic clk = 0, rst_n = 0, wp_n = 1, wel_set = 0, wel_clr = 0, wr_start = 0, sr_start = 0;
  logic [7:0] start_addr = 0, byte_data = 0, rd_addr = 0;
  logic byte_stb = 0, cs_rise = 0, cs_aligned = 0;
  logic [7:0] rd_data, status;

  page_wr_ctrl #(.MEM_BYTES(MB), .PAGE_BYTES(PB), .WR_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wel_set(wel_set), .wel_clr(wel_clr),
    .wr_start(wr_start), .sr_start(sr_start), .start_addr(start_addr),
    .byte_stb(byte_stb), .byte_data(byte_data), .cs_rise(cs_rise),
    .cs_aligned(cs_aligned), .rd_addr(rd_addr), .rd_data(rd_data), .status(status));

  always #2 clk = ~clk;

  int errs = 0, checks = 0;
  bit finished = 0;
  logic [7:0] refm [MB];

  localparam logic [23:0] VEC [5] = '{
    {8'h00, 8'd4,  8'h10},
    {8'h1E, 8'd5,  8'h20},
    {8'h23, 8'd20, 8'h40},
    {8'h58, 8'd1,  8'h77},
    {8'hF0, 8'd16, 8'hA0}
  };

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask
  task automatic wren; wel_set = 1; tick; wel_set = 0; endtask
  task automatic welclr; wel_clr = 1; tick; wel_clr = 0; endtask
  task automatic open_arr(logic [7:0] a); wr_start = 1; start_addr = a; tick; wr_start = 0; endtask
  task automatic open_sr; sr_start = 1; tick; sr_start = 0; endtask
  task automatic send(logic [7:0] b); byte_stb = 1; byte_data = b; tick; byte_stb = 0; endtask
  task automatic csr(bit al); cs_rise = 1; cs_aligned = al; tick; cs_rise = 0; cs_aligned = 0; endtask

  task automatic wait_cycle(string req);
    check(status[0] == 1'b1, req, status[0], 1);
    repeat (WC - 1) tick;
    check(status[0] == 1'b1, req, status[0], 1);
    tick;
    check(status[1:0] == 2'b00, req, status[1:0], 0);
  endtask

  task automatic cmp_page(logic [7:0] base, string req);
    int bad = 0, last_a = 0, last_e = 0;
    for (int i = 0; i < PB; i++) begin
      rd_addr = base + 8'(i);
      #1;
      if (rd_data !== refm[rd_addr]) begin bad++; last_a = rd_data; last_e = refm[rd_addr]; end
    end
    check(bad == 0, req, last_a, last_e);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MB; i++) refm[i] = 8'h00;
    repeat (3) tick;
    rst_n = 1;
    tick;
    check(status == 8'h00, "R1", status, 8'h00);

    for (int v = 0; v < 5; v++) begin
      logic [7:0] a, n, s;
      {a, n, s} = VEC[v];
      wren;
      open_arr(a);
      for (int i = 0; i < n; i++) begin
        send(s + 8'(i));
        refm[{a[7:4], 4'(a[3:0] + 4'(i))}] = s + 8'(i);
      end
      csr(1);
      wait_cycle("R6");
      cmp_page({a[7:4], 4'h0}, "R3 R4");
    end

    // R2: no WEL
    open_arr(8'h00); send(8'hEE); csr(1);
    check(status == 8'h00, "R2", status, 8'h00);
    cmp_page(8'h00, "R2");

    // R5: misaligned edge and empty write
    wren; open_arr(8'h05); send(8'h99); csr(0);
    check(status == 8'h02, "R5", status, 8'h02);
    cmp_page(8'h00, "R5");
    open_arr(8'h05); csr(1);
    check(status == 8'h02, "R5", status, 8'h02);
    welclr;
    check(status == 8'h00, "R2", status, 8'h00);

    // R7 / R10: activity during a cycle
    wren; open_arr(8'h60); send(8'h5A); csr(1);
    rd_addr = 8'h60;
    welclr;
    wp_n = 0;
    open_arr(8'h70);
    send(8'h33);
    wp_n = 1;
    csr(0);
    check(status == 8'h03, "R7", status, 8'h03);
    check(rd_data == refm[8'h60], "R10", rd_data, refm[8'h60]);
    repeat (WC - 5) tick;
    check(status[0] == 1'b1, "R6", status[0], 1);
    tick;
    check(status == 8'h00, "R6", status, 8'h00);
    refm[8'h60] = 8'h5A;
    cmp_page(8'h60, "R7");
    cmp_page(8'h70, "R7");

    // R8: status write
    wren; open_sr; send(8'hFF); send(8'h00); csr(1);
    wait_cycle("R8");
    check(status == 8'h8C, "R8", status, 8'h8C);

    // R9: protect gating
    wp_n = 0;
    wren; open_sr; send(8'h00); csr(1);
    check(status == 8'h8E, "R9", status, 8'h8E);
    wp_n = 1;
    wren; open_sr; send(8'h00); csr(1);
    wait_cycle("R9");
    check(status == 8'h00, "R9", status, 8'h00);
    wp_n = 0;
    wren; open_sr; send(8'h04); csr(1);
    wait_cycle("R9");
    check(status == 8'h04, "R9", status, 8'h04);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule